// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the scan timing for a monitor raster: an active-low horizontal sync, an active-low vertical sync, an active-video flag, and the pixel column and image row of the current position. Every scanline has 800 pixel slots. A single mode input selects one of two frame layouts. One is 525 lines with 480 visible rows, refreshing at 60 Hz. The other is 449 lines with 400 visible rows, refreshing at 70 Hz.

Each pixel slot is stretched over a programmable number of master clocks. The clocks-per-pixel value is clamped to 2..17 when it is taken in. A line-doubling option shows each image row on two consecutive scanlines, which halves the reported row count. Both layouts have an even number of active lines, so doubling always works on whole row pairs.

The mode, clocks-per-pixel and doubling inputs are sampled only during reset and at the first clock of a new frame, so a change made partway through a frame never tears it. A pixel source downstream uses `active`, `col` and `row` to fetch its data. All layout counts are parameters, and the defaults give the two standard layouts.

Top module: `vga_raster_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the position is the frame origin (slot 0 of line 0): `hsync_n`=1, `vsync_n`=0, `active`=0, `col`=0, `row`=0.
- R2: A line is H_ACT+H_FP+H_SY+H_BP slots (default 640+16+96+48=800). Slots are counted from 0, and `hsync_n` is low exactly on slots H_ACT+H_FP up to H_ACT+H_FP+H_SY-1 (656..751 by default).
- R3: With `mode_sel`=0 a frame has T_SY+T_BP+T_ACT+T_FP lines (2+33+480+10=525 by default). Lines are counted from 0. `vsync_n` is low on lines 0..T_SY-1, and the image occupies lines T_SY+T_BP to T_SY+T_BP+T_ACT-1, so the first image line is scanline T_SY+T_BP+1 when counting from 1.
- R4: With `mode_sel`=1 a frame has S_SY+S_BP+S_ACT+S_FP lines (2+35+400+12=449 by default). `vsync_n` is low on lines 0..S_SY-1, and the image occupies lines S_SY+S_BP to S_SY+S_BP+S_ACT-1.
- R5: Each pixel slot lasts N master clocks. N is `cpp_set` clamped to CPP_MIN..CPP_MAX (2..17): values below 2 act as 2, and values above 17 act as 17.
- R6: `active` is high exactly when the slot is below H_ACT and the line lies in the image range. While it is high, `col` equals the slot number. While it is low, `col` and `row` are 0.
- R7: With doubling off, `row` is the line number minus the first image line. With `dbl_en`=1, `row` is that difference divided by 2, so each row appears on two consecutive scanlines.
- R8: The mode, clocks-per-pixel and doubling inputs are taken in during reset and on the clock edge that ends a frame, and at no other time. A change made mid-frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Frame layout: 0 = 480-row layout, 1 = 400-row layout |
| cpp_set | input | CPP_W (5) | Requested master clocks per pixel slot, clamped to 2..17 |
| dbl_en | input | 1 | Repeat each image row on two scanlines |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | Visible pixel position |
| col | output | COL_W (10) | Pixel column while active, else 0 |
| row | output | ROW_W (9) | Image row while active, else 0 |

## Verification
On every cycle the assertions check the following:
- the horizontal sync edges fall on the correct slots;
- vertical sync stays inside the sync lines of the selected layout;
- a frame wraps only on its last line;
- each slot lasts exactly the clamped clocks-per-pixel;
- the sampled configuration stays stable between frame boundaries;
- the outputs stay idle outside the picture.

Only the bench scenarios can show several other properties. These are the exact row numbering with and without doubling, the clamping of out-of-range settings at the edges 0, 1, 18 and 31, and the deferral of a configuration change made in mid-frame until the next frame. The bench shows these by comparing every output on every cycle against a position computed by division from the elapsed cycle count.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;

  typedef enum logic {
    FRAME_TALL  = 1'b0,
    FRAME_SHORT = 1'b1
  } frame_sel_e;

  typedef struct packed {
    logic [15:0] sync_n;
    logic [15:0] back_n;
    logic [15:0] act_n;
    logic [15:0] front_n;
  } v_layout_t;

  function automatic logic [15:0] layout_total(input v_layout_t l);
    return l.sync_n + l.back_n + l.act_n + l.front_n;
  endfunction

  // zero-based index of the first image line
  function automatic logic [15:0] layout_first(input v_layout_t l);
    return l.sync_n + l.back_n;
  endfunction

  function automatic logic [15:0] clamp_span(input logic [15:0] v,
                                             input logic [15:0] lo,
                                             input logic [15:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [15:0] image_row(input logic [15:0] line,
                                            input logic [15:0] first,
                                            input logic dbl);
    logic [15:0] d;
    d = line - first;
    return dbl ? (d >> 1) : d;
  endfunction

endpackage

// File: rtl/vga_cfg_sampler.sv
module vga_cfg_sampler
  import vga_tg_pkg::*;
#(
  parameter int CPP_W   = 5,
  parameter int CPP_MIN = 2,
  parameter int CPP_MAX = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  frame_sel_e       sel_in,
  input  logic [CPP_W-1:0] cpp_in,
  input  logic             dbl_in,
  output frame_sel_e       sel_q,
  output logic [CPP_W-1:0] cpp_q,
  output logic             dbl_q
);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sel_q <= sel_in;
      cpp_q <= CPP_W'(clamp_span(16'(cpp_in), 16'(CPP_MIN), 16'(CPP_MAX)));
      dbl_q <= dbl_in;
    end
  end

endmodule

// File: rtl/vga_slot_timer.sv
module vga_slot_timer #(
  parameter  int H_TOT  = 800,
  parameter  int CPP_W  = 5,
  localparam int SLOT_W = $clog2(H_TOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPP_W-1:0]  cpp,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_adv,
  output logic              line_end
);

  logic [CPP_W-1:0] sub;

  assign slot_adv = (sub == cpp - 1'b1);
  assign line_end = slot_adv && (slot == SLOT_W'(H_TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sub  <= '0;
      slot <= '0;
    end else if (slot_adv) begin
      sub  <= '0;
      slot <= line_end ? '0 : slot + 1'b1;
    end else begin
      sub  <= sub + 1'b1;
    end
  end

endmodule

// File: rtl/vga_line_counter.sv
module vga_line_counter
  import vga_tg_pkg::*;
#(
  parameter int        LINE_W = 10,
  parameter v_layout_t TALL   = '{16'd2, 16'd33, 16'd480, 16'd10},
  parameter v_layout_t SHORT  = '{16'd2, 16'd35, 16'd400, 16'd12}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end,
  input  frame_sel_e        sel,
  output logic [LINE_W-1:0] line,
  output logic              frame_end
);

  localparam logic [15:0] TALL_LAST  = layout_total(TALL) - 16'd1;
  localparam logic [15:0] SHORT_LAST = layout_total(SHORT) - 16'd1;

  logic [15:0] last_line;

  assign last_line = (sel == FRAME_SHORT) ? SHORT_LAST : TALL_LAST;
  assign frame_end = line_end && (16'(line) == last_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (line_end) begin
      line <= frame_end ? '0 : line + 1'b1;
    end
  end

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_tg_pkg::*;
#(
  parameter  int H_ACT   = 640,
  parameter  int H_FP    = 16,
  parameter  int H_SY    = 96,
  parameter  int H_BP    = 48,
  parameter  int T_SY    = 2,
  parameter  int T_BP    = 33,
  parameter  int T_ACT   = 480,
  parameter  int T_FP    = 10,
  parameter  int S_SY    = 2,
  parameter  int S_BP    = 35,
  parameter  int S_ACT   = 400,
  parameter  int S_FP    = 12,
  parameter  int CPP_W   = 5,
  parameter  int CPP_MIN = 2,
  parameter  int CPP_MAX = 17,
  localparam int H_TOT   = H_ACT + H_FP + H_SY + H_BP,
  localparam int T_TOT   = T_SY + T_BP + T_ACT + T_FP,
  localparam int S_TOT   = S_SY + S_BP + S_ACT + S_FP,
  localparam int COL_W   = $clog2(H_TOT),
  localparam int LINE_W  = $clog2((T_TOT > S_TOT) ? T_TOT : S_TOT),
  localparam int ROW_W   = $clog2((T_ACT > S_ACT) ? T_ACT : S_ACT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic [CPP_W-1:0] cpp_set,
  input  logic             dbl_en,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             active,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);

  localparam v_layout_t LAY_T = '{16'(T_SY), 16'(T_BP), 16'(T_ACT), 16'(T_FP)};
  localparam v_layout_t LAY_S = '{16'(S_SY), 16'(S_BP), 16'(S_ACT), 16'(S_FP)};
  localparam logic [15:0] FIRST_T = layout_first(LAY_T);
  localparam logic [15:0] FIRST_S = layout_first(LAY_S);
  localparam logic [15:0] END_T   = FIRST_T + LAY_T.act_n;
  localparam logic [15:0] END_S   = FIRST_S + LAY_S.act_n;
  localparam logic [COL_W-1:0] HS_BEGIN = COL_W'(H_ACT + H_FP);
  localparam logic [COL_W-1:0] HS_END   = COL_W'(H_ACT + H_FP + H_SY);

  // sampled configuration
  frame_sel_e       sel_q;
  logic [CPP_W-1:0] cpp_q;
  logic             dbl_q;

  // named internal events
  logic [COL_W-1:0]  slot;
  logic [LINE_W-1:0] line;
  logic              slot_adv;
  logic              line_end;
  logic              frame_end;

  vga_cfg_sampler #(
    .CPP_W  (CPP_W),
    .CPP_MIN(CPP_MIN),
    .CPP_MAX(CPP_MAX)
  ) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .load  (frame_end),
    .sel_in(frame_sel_e'(mode_sel)),
    .cpp_in(cpp_set),
    .dbl_in(dbl_en),
    .sel_q (sel_q),
    .cpp_q (cpp_q),
    .dbl_q (dbl_q)
  );

  vga_slot_timer #(
    .H_TOT(H_TOT),
    .CPP_W(CPP_W)
  ) u_slot (
    .clk     (clk),
    .rst     (rst),
    .cpp     (cpp_q),
    .slot    (slot),
    .slot_adv(slot_adv),
    .line_end(line_end)
  );

  vga_line_counter #(
    .LINE_W(LINE_W),
    .TALL  (LAY_T),
    .SHORT (LAY_S)
  ) u_line (
    .clk      (clk),
    .rst      (rst),
    .line_end (line_end),
    .sel      (sel_q),
    .line     (line),
    .frame_end(frame_end)
  );

  // raster decode
  logic [15:0] line16;
  logic [15:0] first_line;
  logic [15:0] end_line;
  logic [15:0] sync_lines;
  logic        in_cols;
  logic        in_rows;
  logic        hs_zone;
  logic        vs_zone;

  assign line16     = 16'(line);
  assign first_line = (sel_q == FRAME_SHORT) ? FIRST_S : FIRST_T;
  assign end_line   = (sel_q == FRAME_SHORT) ? END_S : END_T;
  assign sync_lines = (sel_q == FRAME_SHORT) ? LAY_S.sync_n : LAY_T.sync_n;

  assign in_cols = (slot < COL_W'(H_ACT));
  assign in_rows = (line16 >= first_line) && (line16 < end_line);
  assign hs_zone = (slot >= HS_BEGIN) && (slot < HS_END);
  assign vs_zone = (line16 < sync_lines);

  assign hsync_n = ~hs_zone;
  assign vsync_n = ~vs_zone;
  assign active  = in_cols && in_rows;
  assign col     = active ? slot : '0;
  assign row     = active ? ROW_W'(image_row(line16, first_line, dbl_q)) : '0;

endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk #(
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SY    = 96,
  parameter int T_SY    = 2,
  parameter int S_SY    = 2,
  parameter int T_TOT   = 525,
  parameter int S_TOT   = 449,
  parameter int CPP_W   = 5,
  parameter int CPP_MIN = 2,
  parameter int CPP_MAX = 17,
  parameter int COL_W   = 10,
  parameter int LINE_W  = 10,
  parameter int ROW_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              active,
  input logic [COL_W-1:0]  col,
  input logic [ROW_W-1:0]  row,
  input logic [COL_W-1:0]  slot,
  input logic [LINE_W-1:0] line,
  input logic              slot_adv,
  input logic              frame_end,
  input logic              sel_q,
  input logic [CPP_W-1:0]  cpp_q,
  input logic              dbl_q
);

  logic [CPP_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || slot_adv) run_len <= '0;
    else                 run_len <= run_len + 1'b1;
  end

  AST_RESET_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot == '0) && (line == '0));  // R1

  AST_HSYNC_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> slot == COL_W'(H_ACT + H_FP));  // R2

  AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> slot == COL_W'(H_ACT + H_FP + H_SY));  // R2

  AST_VSYNC_LINES: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> 32'(line) < (sel_q ? S_SY : T_SY));  // R3

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> 32'(line) == (sel_q ? S_TOT - 1 : T_TOT - 1));  // R4

  AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    slot_adv |-> run_len == cpp_q - 1'b1);  // R5

  AST_CPP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (32'(cpp_q) >= CPP_MIN) && (32'(cpp_q) <= CPP_MAX));  // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !active |-> (col == '0) && (row == '0));  // R6

  AST_ACTIVE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    active |-> hsync_n && vsync_n);  // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_end) && !$past(rst)) |-> $stable({sel_q, cpp_q, dbl_q}));  // R8

endmodule

bind vga_raster_gen vga_raster_chk #(
  .H_ACT  (H_ACT),
  .H_FP   (H_FP),
  .H_SY   (H_SY),
  .T_SY   (T_SY),
  .S_SY   (S_SY),
  .T_TOT  (T_TOT),
  .S_TOT  (S_TOT),
  .CPP_W  (CPP_W),
  .CPP_MIN(CPP_MIN),
  .CPP_MAX(CPP_MAX),
  .COL_W  (COL_W),
  .LINE_W (LINE_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .active   (active),
  .col      (col),
  .row      (row),
  .slot     (slot),
  .line     (line),
  .slot_adv (slot_adv),
  .frame_end(frame_end),
  .sel_q    (sel_q),
  .cpp_q    (cpp_q),
  .dbl_q    (dbl_q)
);

// File: tb/vga_raster_gen_test.sv
`timescale 1ns/1ps
module vga_raster_gen_test;

  localparam int H_ACT = 16, H_FP = 2, H_SY = 4, H_BP = 3;
  localparam int T_SY = 2, T_BP = 3, T_ACT = 8, T_FP = 4;
  localparam int S_SY = 2, S_BP = 4, S_ACT = 6, S_FP = 3;
  localparam int H_TOT = H_ACT + H_FP + H_SY + H_BP;
  localparam int T_TOT = T_SY + T_BP + T_ACT + T_FP;
  localparam int S_TOT = S_SY + S_BP + S_ACT + S_FP;
  localparam int COL_W = $clog2(H_TOT);
  localparam int ROW_W = $clog2(T_ACT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic [4:0] cpp_set = 5'd2;
  logic dbl_en = 1'b0;
  logic hsync_n, vsync_n, active;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  vga_raster_gen #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .T_SY(T_SY), .T_BP(T_BP), .T_ACT(T_ACT), .T_FP(T_FP),
    .S_SY(S_SY), .S_BP(S_BP), .S_ACT(S_ACT), .S_FP(S_FP)
  ) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cpp_set(cpp_set),
    .dbl_en(dbl_en), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .col(col), .row(row)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  int f = 0;
  int frames = 0;
  int exp_cpp = 2;
  bit exp_short = 1'b0;
  bit exp_dbl = 1'b0;
  int k = 0;

  int dir_mode [6] = '{1, 0, 1, 0, 1, 0};
  int dir_cpp  [6] = '{2, 0, 31, 1, 18, 17};
  int dir_dbl  [6] = '{1, 1, 0, 0, 1, 1};

  function automatic int clamp_b(input int v);
    return (v < 2) ? 2 : ((v > 17) ? 17 : v);
  endfunction

  function automatic int flen();
    return exp_cpp * H_TOT * (exp_short ? S_TOT : T_TOT);
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d (f=%0d)", tag, what, got, exp, f);
    end
  endtask

  task automatic compare_now();
    int per_line = exp_cpp * H_TOT;
    int line = f / per_line;
    int slot = (f % per_line) / exp_cpp;
    int first = exp_short ? (S_SY + S_BP) : (T_SY + T_BP);
    int nact = exp_short ? S_ACT : T_ACT;
    int nsync = exp_short ? S_SY : T_SY;
    bit act = (slot < H_ACT) && (line >= first) && (line < first + nact);
    bit hs = !((slot >= H_ACT + H_FP) && (slot < H_ACT + H_FP + H_SY));
    bit vs = !(line < nsync);
    int erow = act ? (exp_dbl ? (line - first) / 2 : (line - first)) : 0;
    bit pending = (clamp_b(int'(cpp_set)) != exp_cpp) || (mode_sel != exp_short) ||
                  (dbl_en != exp_dbl);
    check("R2", "hsync_n", int'(hsync_n), int'(hs));
    check(exp_short ? "R4" : "R3", "vsync_n", int'(vsync_n), int'(vs));
    check("R6", "active", int'(active), int'(act));
    check(pending ? "R8" : "R5", "col", int'(col), act ? slot : 0);
    check(exp_dbl ? "R7" : "R6", "row", int'(row), erow);
  endtask

  task automatic apply_next();
    if (k < 6) begin
      mode_sel = dir_mode[k][0];
      cpp_set  = 5'(dir_cpp[k]);
      dbl_en   = dir_dbl[k][0];
    end else begin
      mode_sel = 1'($urandom_range(1, 0));
      cpp_set  = 5'($urandom_range(31, 0));
      dbl_en   = 1'($urandom_range(1, 0));
    end
    k++;
  endtask

  task automatic advance();
    if (f == flen() - 1) begin
      exp_short = mode_sel;
      exp_cpp   = clamp_b(int'(cpp_set));
      exp_dbl   = dbl_en;
      f = 0;
      frames++;
    end else begin
      f++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input bit m, input int c, input bit d);
    @(negedge clk);
    mode_sel = m;
    cpp_set  = 5'(c);
    dbl_en   = d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "hsync_n in reset", int'(hsync_n), 1);
    check("R1", "active in reset", int'(active), 0);
    exp_short = m;
    exp_cpp   = clamp_b(c);
    exp_dbl   = d;
    f = 0;
    rst = 1'b0;
    check("R1", "hsync_n", int'(hsync_n), 1);
    check("R1", "vsync_n", int'(vsync_n), 0);
    check("R1", "active", int'(active), 0);
    check("R1", "col", int'(col), 0);
    check("R1", "row", int'(row), 0);
  endtask

  task automatic run_until(input int target);
    while (frames < target) begin
      advance();
      compare_now();
      if (f == flen() / 2) apply_next();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0, 2, 1'b0);
    run_until(13);
    do_reset(1'b1, 31, 1'b1);  // R1 with an out-of-range setting, R5 clamp to 17
    run_until(frames + 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule